// File: doc/BRIEF.md
# Self-Timed Program/Erase Sequencer

This block runs the commands that change the contents of a small non-volatile word array: erase of one word, write of one word, erase of every word and write of one value to every word. A serial command decoder hands over a complete command with a one-cycle strobe while chip select is high. The operation then waits for chip select to fall. From that point it counts system-clock cycles to model the program/erase time and needs no serial clock activity.

While an operation is running, the host can raise chip select and poll the data-out pin. The pin is driven low while the array is still busy and high once it is ready. When the block is ready, a 1 sampled on the data-in line at a serial clock rising edge returns the pin to high impedance. Requests that arrive during an operation are dropped, and a sticky flag records that this happened. The array is updated only in the last busy cycle, so a read during an operation returns the old contents.

Top module: `pe_seq`

## Requirements
- R1: After reset the array holds all ones in every word, `busy_o`, `do_oe_o` and `dropped_o` are low, and no command is pending.
- R2: A command taken while idle starts on the first clock that samples `cs_i` low after it was sampled high. A single-word operation (`cmd_op_i` 2'b00 erase, 2'b01 write) keeps `busy_o` high for exactly WORD_CYCLES clocks.
- R3: An all-word operation (`cmd_op_i` 2'b10 erase all, 2'b11 write all) keeps `busy_o` high for exactly BULK_CYCLES clocks.
- R4: A word write leaves the addressed word equal to `cmd_data_i` whatever it held before, including bits that go from 0 to 1.
- R5: A word erase sets the addressed word to all ones and leaves every other word unchanged.
- R6: Erase-all sets every word to all ones, and write-all sets every word to the command data.
- R7: The array changes in the last busy cycle only. While `busy_o` is high, `rd_data_o` shows the old contents.
- R8: While status is enabled and `cs_i` is high, `do_oe_o` is high and `do_o` equals the inverse of `busy_o`. An operation start enables status.
- R9: A `sk_rise_i` pulse with `di_i`=1 while `cs_i` is high and the block is ready disables status (`do_oe_o` low). The same pulse while busy, or a pulse with `di_i`=0, has no effect.
- R10: A `cmd_valid_i` strobe while busy is discarded: it starts no operation and changes no word, and it sets `dropped_o`, which then stays high until reset.
- R11: `do_oe_o` is low whenever `cs_i` is low. A falling edge of `cs_i` with no pending command starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle strobe: a complete command frame |
| cmd_op_i | input | 2 | Operation code (see R2, R3) |
| cmd_addr_i | input | ADDR_W | Target word address |
| cmd_data_i | input | DATA_W | Write data |
| cs_i | input | 1 | Chip select, synchronous to clk_i |
| sk_rise_i | input | 1 | One-cycle pulse at a serial clock rising edge |
| di_i | input | 1 | Serial data-in level at that edge |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Array read data (combinational) |
| busy_o | output | 1 | Operation in progress |
| do_o | output | 1 | Data-out level: 0 busy, 1 ready |
| do_oe_o | output | 1 | Data-out drive enable |
| dropped_o | output | 1 | Sticky: a request arrived while busy |

## Verification
A wrong cycle counter shows up first at `busy_o`, whose high time for each operation the bench compares on every clock. A wrong address decode or data select shows up at `rd_data_o` in the clock after the last busy cycle. An early array update is visible during the busy window itself. A fault in the status flag shows up on `do_oe_o` within one clock of the serial clock pulse or chip select change that should have moved it, and a stray pending command shows up as a `busy_o` rise on the next chip select fall.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;
  typedef enum logic [1:0] {
    OP_ERASE     = 2'b00,
    OP_WRITE     = 2'b01,
    OP_ERASE_ALL = 2'b10,
    OP_WRITE_ALL = 2'b11
  } pe_op_e;

  function automatic logic op_is_bulk(input pe_op_e op);
    return op[1];
  endfunction

  function automatic logic op_has_data(input pe_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/pe_timer.sv
module pe_timer #(
  parameter int WORD_CYCLES = 30,
  parameter int BULK_CYCLES = 50,
  localparam int CntW = $clog2(BULK_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bulk_i,
  output logic busy_o,
  output logic last_o
);
  localparam logic [CntW-1:0] WordLoad = CntW'(WORD_CYCLES - 1);
  localparam logic [CntW-1:0] BulkLoad = CntW'(BULK_CYCLES - 1);

  logic [CntW-1:0] cnt_q;
  logic            busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= bulk_i ? BulkLoad : WordLoad;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pe_status.sv
module pe_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic busy_i,
  input  logic cs_i,
  input  logic sk_rise_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic stat_q;

  // dummy 1 only honoured when ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        stat_q <= 1'b0;
    else if (start_i)                                   stat_q <= 1'b1;
    else if (stat_q && cs_i && sk_rise_i && di_i && !busy_i) stat_q <= 1'b0;
  end

  assign do_oe_o = cs_i & stat_q;
  assign do_o    = do_oe_o & ~busy_i;
endmodule

// File: rtl/pe_array.sv
module pe_array
  import pe_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int Depth = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  pe_op_e            op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] words [Depth];
  logic [DATA_W-1:0] new_val;

  // auto-clear then program collapses to a plain store
  assign new_val = op_has_data(op_i) ? data_i : '1;

  for (genvar w = 0; w < Depth; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = upd_i && (op_is_bulk(op_i) || (addr_i == ADDR_W'(w)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '1;
      else if (hit) word_q <= new_val;
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];
endmodule

// File: rtl/pe_seq.sv
module pe_seq
  import pe_seq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int WORD_CYCLES = 30,
  parameter int BULK_CYCLES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  input  logic              di_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              dropped_o
);
  logic              cs_q, pend_q, drop_q;
  pe_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              busy, last, start, accept;

  assign start  = cs_q && !cs_i && pend_q && !busy;
  assign accept = cmd_valid_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      pend_q <= 1'b0;
      drop_q <= 1'b0;
      op_q   <= OP_ERASE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      cs_q <= cs_i;
      if (cmd_valid_i && busy) drop_q <= 1'b1;
      if (start) pend_q <= 1'b0;
      else if (accept) begin
        pend_q <= 1'b1;
        op_q   <= pe_op_e'(cmd_op_i);
        addr_q <= cmd_addr_i;
        data_q <= cmd_data_i;
      end
    end
  end

  pe_timer #(.WORD_CYCLES(WORD_CYCLES), .BULK_CYCLES(BULK_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .bulk_i(op_is_bulk(op_q)),
    .busy_o(busy), .last_o(last)
  );

  pe_status u_status (
    .clk_i, .rst_ni, .start_i(start), .busy_i(busy), .cs_i,
    .sk_rise_i, .di_i, .do_o, .do_oe_o
  );

  pe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni, .upd_i(last), .op_i(op_q), .addr_i(addr_q),
    .data_i(data_q), .rd_addr_i, .rd_data_o
  );

  assign busy_o    = busy;
  assign dropped_o = drop_q;
endmodule

// File: rtl/pe_seq_chk.sv
module pe_seq_chk #(
  parameter int WORD_CYCLES = 30,
  parameter int BULK_CYCLES = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cs_i,
  input logic busy_o,
  input logic do_o,
  input logic do_oe_o,
  input logic dropped_o
);
  logic [15:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 16'(WORD_CYCLES) || run_q == 16'(BULK_CYCLES)));
  // R2
  start_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(!cs_i) && $past(cs_i, 2)));
  // R8
  busy_shows_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && busy_o) |-> !do_o);
  // R9
  no_off_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && busy_o) |=> (do_oe_o || !cs_i));
  // R10
  drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dropped_o) |-> ($past(busy_o) && $past(cmd_valid_i)));
  // R10
  drop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dropped_o |=> dropped_o);
  // R11
  idle_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !do_oe_o);
endmodule

bind pe_seq pe_seq_chk #(.WORD_CYCLES(WORD_CYCLES), .BULK_CYCLES(BULK_CYCLES)) u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cs_i, .busy_o, .do_o, .do_oe_o, .dropped_o
);

// File: tb/pe_seq_bench.sv
module pe_seq_bench;
  localparam int AW = 6, DW = 16, WC = 30, BC = 50, DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic cmd_v = 0, cs = 0, sk = 0, di = 0;
  logic [1:0] op = 0;
  logic [AW-1:0] addr = 0, rd = 0;
  logic [DW-1:0] data = 0;
  logic [DW-1:0] rd_data;
  logic busy, dout, doe, drop;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pe_seq #(.ADDR_W(AW), .DATA_W(DW), .WORD_CYCLES(WC), .BULK_CYCLES(BC)) u_pe_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_v), .cmd_op_i(op),
    .cmd_addr_i(addr), .cmd_data_i(data), .cs_i(cs), .sk_rise_i(sk), .di_i(di),
    .rd_addr_i(rd), .rd_data_o(rd_data), .busy_o(busy), .do_o(dout),
    .do_oe_o(doe), .dropped_o(drop)
  );

  // reference model
  int unsigned mem [DEPTH];
  bit m_busy, m_pend, m_stat, m_drop, m_csq, m_fall, m_st, m_pre;
  int m_left, m_op, m_addr;
  int unsigned m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_stat = 0; m_drop = 0; m_csq = 0; m_left = 0;
      foreach (mem[i]) mem[i] = 16'hFFFF;
    end else begin
      m_fall = m_csq && !cs;
      m_st = 0;
      m_pre = m_busy;
      if (m_pre) begin
        if (cmd_v) m_drop = 1;
        if (m_left == 1) begin
          for (int i = 0; i < DEPTH; i++)
            if (m_op >= 2 || i == m_addr) mem[i] = (m_op % 2 == 1) ? m_data : 16'hFFFF;
          m_busy = 0;
        end else m_left--;
      end else if (m_fall && m_pend) begin
        m_st = 1; m_busy = 1; m_pend = 0;
        m_left = (m_op >= 2) ? BC : WC;
      end else if (cmd_v) begin
        m_pend = 1; m_op = op; m_addr = addr; m_data = data;
      end
      if (m_st) m_stat = 1;
      else if (sk && di && cs && !m_pre && m_stat) m_stat = 0;
      m_csq = cs;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      chk("R2 busy", busy, m_busy);
      chk("R8 do_oe", doe, cs && m_stat);
      chk("R8 do", dout, cs && m_stat && !m_busy);
      chk("R10 dropped", drop, m_drop);
      chk("R7 rd_data", rd_data, mem[rd]);
    end
  end

  task automatic issue(input logic [1:0] o, input int a, input logic [DW-1:0] d);
    @(negedge clk); cs = 1; cmd_v = 1; op = o; addr = AW'(a); data = d;
    @(negedge clk); cmd_v = 0;
    @(negedge clk); cs = 0;
  endtask

  task automatic measure(output int n, input bit chk_old, input logic [DW-1:0] old_v);
    n = 0;
    @(negedge clk); #2;
    while (busy) begin
      n++;
      if (chk_old) chk("R7 old data during busy", rd_data, old_v);
      @(negedge clk); #2;
    end
  endtask

  task automatic rd_word(input int a, output logic [DW-1:0] v);
    @(negedge clk); rd = AW'(a); #1; v = rd_data;
  endtask

  task automatic sk_pulse(input logic d);
    @(negedge clk); sk = 1; di = d;
    @(negedge clk); sk = 0; di = 0; #3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [DW-1:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1;
    #3;
    chk("R1 busy", busy, 0);
    chk("R1 do_oe", doe, 0);
    chk("R1 dropped", drop, 0);
    rd_word(5, v); chk("R1 erased", v, 16'hFFFF);

    // word write with old data visible during busy
    @(negedge clk); rd = 3;
    issue(2'b01, 3, 16'h1234);
    measure(n, 1, 16'hFFFF);
    chk("R2 word busy cycles", n, WC);
    chk("R7 new data after busy", rd_data, 16'h1234);

    issue(2'b01, 3, 16'hA5C3);
    measure(n, 1, 16'h1234);
    chk("R2 word busy cycles", n, WC);
    rd_word(3, v); chk("R4 overwrite", v, 16'hA5C3);

    issue(2'b01, 4, 16'h0000); measure(n, 0, 0);
    issue(2'b00, 3, 16'h0000); measure(n, 0, 0);
    chk("R2 erase busy cycles", n, WC);
    rd_word(3, v); chk("R5 erased word", v, 16'hFFFF);
    rd_word(4, v); chk("R5 neighbour kept", v, 16'h0000);

    issue(2'b11, 0, 16'h0F0F); measure(n, 0, 0);
    chk("R3 bulk busy cycles", n, BC);
    rd_word(0, v);  chk("R6 write all lo", v, 16'h0F0F);
    rd_word(4, v);  chk("R6 write all mid", v, 16'h0F0F);
    rd_word(63, v); chk("R6 write all hi", v, 16'h0F0F);

    issue(2'b10, 0, 16'h0000); measure(n, 0, 0);
    chk("R3 bulk busy cycles", n, BC);
    rd_word(0, v);  chk("R6 erase all lo", v, 16'hFFFF);
    rd_word(17, v); chk("R6 erase all mid", v, 16'hFFFF);
    rd_word(63, v); chk("R6 erase all hi", v, 16'hFFFF);

    // status polling, dummy bit, dropped request
    issue(2'b01, 9, 16'h0042);
    @(negedge clk); cs = 1; #3;
    chk("R8 busy oe", doe, 1);
    chk("R8 busy level", dout, 0);
    sk_pulse(1);
    chk("R9 no off while busy", doe, 1);
    @(negedge clk); cmd_v = 1; op = 2'b01; addr = 10; data = 16'h0000;
    @(negedge clk); cmd_v = 0; #3;
    chk("R10 dropped set", drop, 1);
    while (busy) @(negedge clk);
    #3;
    chk("R8 ready oe", doe, 1);
    chk("R8 ready level", dout, 1);
    sk_pulse(0);
    chk("R9 zero bit ignored", doe, 1);
    sk_pulse(1);
    chk("R9 dummy one off", doe, 0);
    @(negedge clk); cs = 0;
    @(negedge clk); #2;
    chk("R10 dropped cmd not started", busy, 0);
    rd_word(10, v); chk("R10 word untouched", v, 16'hFFFF);
    rd_word(9, v);  chk("R4 write landed", v, 16'h0042);

    // cs fall with nothing pending
    @(negedge clk); cs = 1; #3;
    chk("R9 status stays off", doe, 0);
    @(negedge clk); cs = 0;
    repeat (2) @(negedge clk);
    #2;
    chk("R11 no start", busy, 0);
    chk("R11 pin off with cs low", doe, 0);
    chk("R10 sticky", drop, 1);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule